// File: doc/BRIEF.md
# Registered Eight-Function 16-bit ALU

This block is a 16-bit arithmetic and logic unit with a registered output. Each cycle it takes two operands and a 3-bit function code. All function units work in parallel on the same operands:

- a ripple-carry adder/subtractor;
- a three-column left shifter;
- bitwise AND and OR;
- a pass-through path;
- a tree-reduced multiplier.

A multiplexer selects one unit's value, and the result register captures it on the rising clock edge. A surrounding datapath drives the operands and the code ahead of an edge and reads the result after that edge.

The no-operation code leaves the result register at its previous value, so the last result stays visible. The shifter stages move data by 1, 2 and 3 positions. A small decode turns the requested amount into the three stage enables.

Top module: `alu8_top`

## Requirements
- R1: Code 3'b000 loads result with (a + b) mod 2^16.
- R2: Code 3'b001 loads result with (a - b) mod 2^16, formed as a + ~b + 1.
- R3: Code 3'b010 loads result with a shifted left, zero-filled, by the amount in b[2:0]; an amount of 7 acts as 6, and b[15:3] has no effect.
- R4: Code 3'b011 loads result with a & b.
- R5: Code 3'b100 loads result with a | b.
- R6: Code 3'b101 loads result with a unchanged.
- R7: Code 3'b110 loads result with the low 16 bits of the unsigned product a * b.
- R8: Code 3'b111 leaves result equal to its previous value, whatever a and b are.
- R9: A high rst at a rising edge clears result to 0, overriding any function code.
- R10: result changes only at a rising edge. It reflects the inputs present at that edge and stays steady between edges while the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 16 | First operand |
| b | input | 16 | Second operand; b[2:0] is the shift amount |
| fsel | input | 3 | Function code |
| result | output | 16 | Registered result |

## Verification
The only state is the result register, so any fault shows in result on the edge after the code that exposes it.

- A broken carry link in the ripple chain shows up as a wrong sum only when operands drive a carry through that bit. The bench therefore uses all-ones and 0x8000 operands.
- A wrong stage enable in the shifter appears only for certain amounts, so all eight amounts are applied.
- A faulty hold path is caught by a no-operation cycle that presents new operands.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_SHL  = 3'b010,
        OP_AND  = 3'b011,
        OP_OR   = 3'b100,
        OP_PASS = 3'b101,
        OP_MUL  = 3'b110,
        OP_NOP  = 3'b111
    } alu_op_e;

    // Map a requested shift of 0..7 onto the enables of the
    // 1-, 2- and 3-position columns (bit0 = 1, bit1 = 2, bit2 = 3).
    // 7 is clamped to 6, the largest reachable sum.
    function automatic logic [2:0] shift_enables(input logic [2:0] amt);
        case (amt)
            3'd0:    return 3'b000;
            3'd1:    return 3'b001;
            3'd2:    return 3'b010;
            3'd3:    return 3'b100;
            3'd4:    return 3'b101;
            3'd5:    return 3'b110;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/alu8_ripple.sv
module alu8_ripple #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         invert_y,
    output logic [W-1:0] sum
);
    logic [W:0]   carry;
    logic [W-1:0] y_eff;

    assign y_eff    = invert_y ? ~y : y;
    assign carry[0] = invert_y;

    for (genvar i = 0; i < W; i++) begin : g_cell
        assign sum[i]     = x[i] ^ y_eff[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y_eff[i]) | (carry[i] & (x[i] ^ y_eff[i]));
    end

    logic unused_cout;
    assign unused_cout = carry[W];
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
    parameter int W      = 16,
    parameter int STAGES = 3
) (
    input  logic [W-1:0]  din,
    input  logic [2:0]    amt,
    output logic [W-1:0]  dout
);
    import alu8_pkg::*;

    logic [STAGES-1:0] en;
    logic [W-1:0]      col [STAGES+1];

    assign en     = shift_enables(amt);
    assign col[0] = din;

    for (genvar s = 0; s < STAGES; s++) begin : g_col
        localparam int SH = s + 1;
        for (genvar i = 0; i < W; i++) begin : g_mux
            if (i >= SH) begin : g_mv
                assign col[s+1][i] = en[s] ? col[s][i-SH] : col[s][i];
            end else begin : g_zf
                assign col[s+1][i] = en[s] ? 1'b0 : col[s][i];
            end
        end
    end

    assign dout = col[STAGES];
endmodule

// File: rtl/alu8_mult.sv
module alu8_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] prod
);
    logic [W-1:0] rows [W];
    logic [W-1:0] nrow [W];
    int           live;
    int           made;

    // Carry-save reduction: groups of three rows become a sum row and a
    // shifted carry row, level by level, until two rows remain.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            rows[i] = y[i] ? (x << i) : '0;
            nrow[i] = '0;
        end
        live = W;
        made = 0;
        for (int lvl = 0; lvl < W; lvl++) begin
            if (live > 2) begin
                for (int i = 0; i < W; i++) nrow[i] = '0;
                made = 0;
                for (int g = 0; g < W; g += 3) begin
                    if (g + 2 < live) begin
                        nrow[made]   = rows[g] ^ rows[g+1] ^ rows[g+2];
                        nrow[made+1] = ((rows[g] & rows[g+1]) | (rows[g] & rows[g+2])
                                       | (rows[g+1] & rows[g+2])) << 1;
                        made = made + 2;
                    end else if (g < live) begin
                        nrow[made] = rows[g];
                        made = made + 1;
                        if (g + 1 < live) begin
                            nrow[made] = rows[g+1];
                            made = made + 1;
                        end
                    end
                end
                for (int i = 0; i < W; i++) rows[i] = nrow[i];
                live = made;
            end
        end
    end

    alu8_ripple #(.W(W)) u_cpa (
        .x        (rows[0]),
        .y        (rows[1]),
        .invert_y (1'b0),
        .sum      (prod)
    );
endmodule

// File: rtl/alu8_top.sv
module alu8_top #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   fsel,
    output logic [W-1:0] result
);
    import alu8_pkg::*;

    alu_op_e      op;
    logic [W-1:0] addsub_q, shift_q, mult_q, pick;

    assign op = alu_op_e'(fsel);

    alu8_ripple #(.W(W)) u_addsub (
        .x        (a),
        .y        (b),
        .invert_y (op == OP_SUB),
        .sum      (addsub_q)
    );

    alu8_shifter #(.W(W), .STAGES(3)) u_shift (
        .din  (a),
        .amt  (b[2:0]),
        .dout (shift_q)
    );

    alu8_mult #(.W(W)) u_mult (
        .x    (a),
        .y    (b),
        .prod (mult_q)
    );

    always_comb begin
        case (op)
            OP_ADD,
            OP_SUB:  pick = addsub_q;
            OP_SHL:  pick = shift_q;
            OP_AND:  pick = a & b;
            OP_OR:   pick = a | b;
            OP_PASS: pick = a;
            OP_MUL:  pick = mult_q;
            default: pick = result;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)               result <= '0;
        else if (op != OP_NOP) result <= pick;
    end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [2:0]   fsel,
    input logic [W-1:0] result
);
    logic [W-1:0] sum_ref;
    assign sum_ref = W'(a + b);

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> result == '0);

    p_add_r1: assert property (@(posedge clk) disable iff (rst)
        fsel == 3'b000 |=> result == $past(sum_ref));

    p_and_r4: assert property (@(posedge clk) disable iff (rst)
        fsel == 3'b011 |=> result == ($past(a) & $past(b)));

    p_or_r5: assert property (@(posedge clk) disable iff (rst)
        fsel == 3'b100 |=> result == ($past(a) | $past(b)));

    p_pass_r6: assert property (@(posedge clk) disable iff (rst)
        fsel == 3'b101 |=> result == $past(a));

    p_nop_hold_r8: assert property (@(posedge clk) disable iff (rst)
        fsel == 3'b111 |=> $stable(result));
endmodule

bind alu8_top alu8_chk #(.W(W)) u_chk (.*);

// File: tb/alu8_top_test.sv
module alu8_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a = '0, b = '0;
    logic [2:0]  fsel = 3'b111;
    logic [15:0] result;
    logic [15:0] held = '0;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    alu8_top uut (.clk(clk), .rst(rst), .a(a), .b(b), .fsel(fsel), .result(result));

    function automatic logic [15:0] model(input logic [2:0] f, input logic [15:0] x,
                                          input logic [15:0] y, input logic [15:0] prev);
        int amt;
        logic [31:0] p;
        amt = (y[2:0] == 3'd7) ? 6 : int'(y[2:0]);
        p = 32'(x) * 32'(y);
        case (f)
            3'b000: return x + y;
            3'b001: return x - y;
            3'b010: return x << amt;
            3'b011: return x & y;
            3'b100: return x | y;
            3'b101: return x;
            3'b110: return p[15:0];
            default: return prev;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: result=%h expected=%h", req, got, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the next rising edge.
    task automatic apply(input string req, input logic [2:0] f,
                         input logic [15:0] x, input logic [15:0] y);
        logic [15:0] e;
        @(negedge clk);
        fsel = f; a = x; b = y;
        e = model(f, x, y, held);
        @(posedge clk); #1;
        check(req, result, e);
        held = e;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1; fsel = 3'b000; a = 16'h1234; b = 16'h1111;
        @(posedge clk); #1;
        check("R9", result, 16'h0000);
        held = '0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_add_sub();
        apply("R1", 3'b000, 16'h0001, 16'h0002);
        apply("R1", 3'b000, 16'hFFFF, 16'h0001);
        apply("R1", 3'b000, 16'h8000, 16'h8000);
        apply("R1", 3'b000, 16'h7FFF, 16'h7FFF);
        apply("R2", 3'b001, 16'h0005, 16'h0003);
        apply("R2", 3'b001, 16'h0000, 16'h0001);
        apply("R2", 3'b001, 16'h8000, 16'hFFFF);
        apply("R2", 3'b001, 16'h1234, 16'h1234);
    endtask

    task automatic t_shift();
        for (int k = 0; k < 8; k++) apply("R3", 3'b010, 16'h8001, 16'(k));
        apply("R3", 3'b010, 16'hFFFF, 16'hFFF8);
        apply("R3", 3'b010, 16'h00A5, 16'h5553);
        apply("R3", 3'b010, 16'h0001, 16'h0007);
    endtask

    task automatic t_logic_pass();
        apply("R4", 3'b011, 16'hF0F0, 16'hFF00);
        apply("R4", 3'b011, 16'hFFFF, 16'h0000);
        apply("R5", 3'b100, 16'hF0F0, 16'h0F0F);
        apply("R5", 3'b100, 16'h0000, 16'h8000);
        apply("R6", 3'b101, 16'hBEEF, 16'h1234);
        apply("R6", 3'b101, 16'h0000, 16'hFFFF);
    endtask

    task automatic t_mult();
        apply("R7", 3'b110, 16'h0003, 16'h0007);
        apply("R7", 3'b110, 16'hFFFF, 16'hFFFF);
        apply("R7", 3'b110, 16'h8000, 16'h0002);
        apply("R7", 3'b110, 16'h00FF, 16'h0101);
        apply("R7", 3'b110, 16'h0000, 16'hFFFF);
    endtask

    task automatic t_nop();
        apply("R1", 3'b000, 16'h1000, 16'h0234);
        apply("R8", 3'b111, 16'hFFFF, 16'hFFFF);
        apply("R8", 3'b111, 16'h0000, 16'h8000);
        check("R8", result, 16'h1234);
    endtask

    task automatic t_timing();
        apply("R10", 3'b101, 16'h5A5A, 16'h0000);
        @(negedge clk); a = 16'h0F0F; fsel = 3'b011; b = 16'hFFFF;
        #2 check("R10", result, 16'h5A5A);
        @(posedge clk); #1;
        check("R10", result, 16'h0F0F);
        held = 16'h0F0F;
    endtask

    task automatic t_random();
        for (int n = 0; n < 200; n++) begin
            logic [2:0] f = 3'($urandom_range(0, 7));
            string r;
            case (f)
                3'b000: r = "R1"; 3'b001: r = "R2"; 3'b010: r = "R3"; 3'b011: r = "R4";
                3'b100: r = "R5"; 3'b101: r = "R6"; 3'b110: r = "R7"; default: r = "R8";
            endcase
            apply(r, f, 16'($urandom), 16'($urandom));
        end
    endtask

    task automatic t_reset_late();
        apply("R1", 3'b000, 16'h0101, 16'h0101);
        @(negedge clk); rst = 1'b1; fsel = 3'b110; a = 16'h0003; b = 16'h0003;
        @(posedge clk); #1;
        check("R9", result, 16'h0000);
        @(negedge clk); rst = 1'b0; fsel = 3'b111;
        held = '0;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: result=%h expected=completion", result);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_add_sub();
        t_shift();
        t_logic_pass();
        t_mult();
        t_nop();
        t_timing();
        t_random();
        t_reset_late();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule